// File: doc/BRIEF.md
# Indexed and Indirect Effective Address Unit

This unit forms the 16-bit effective address for five addressing modes of an 8-bit processor core: zero-page indexed by X, zero-page indexed by Y, pre-indexed indirect through page zero, post-indexed indirect through page zero, and the relative branch target. The core pulses `start` with the mode, the operand byte, both index registers and the program counter. It then waits for a single-cycle `done` that carries the result on `eff_addr`.

The two direct modes and the branch mode need no memory traffic. They complete one cycle after `start`. The two indirect modes fetch a two-byte pointer from page zero through a plain read port with one cycle of latency, low byte first. Each pointer access and each zero-page index wraps inside page zero and never spills into page one. The post-indexed sum and the branch target wrap modulo the 16-bit address space. While an operation is in flight, `busy` is high and any new `start` is dropped.

Top module: `eag_top`

## Requirements
- R1: After reset, `done`, `busy` and `mem_rd_en` are 0 and `eff_addr` is 0x0000.
- R2: Mode code 0 (zero-page by X) gives `eff_addr` = (operand + X) mod 256 with the upper byte 0. `done` rises in the cycle after the start cycle, and no read is issued.
- R3: Mode code 1 (zero-page by Y) gives `eff_addr` = (operand + Y) mod 256 with the upper byte 0. `done` rises in the cycle after the start cycle, and no read is issued.
- R4: Mode code 2 (pre-indexed indirect) reads the low pointer byte at (operand + X) mod 256, then the high byte at (operand + X + 1) mod 256. `eff_addr` = high*256 + low.
- R5: Mode code 3 (post-indexed indirect) reads the low pointer byte at the operand, then the high byte at (operand + 1) mod 256. `eff_addr` = (high*256 + low + Y) mod 65536.
- R6: Mode code 4 (relative) treats the operand as a two's-complement byte: values 0x80 and above mean operand - 256. `eff_addr` = (PC + offset) mod 65536, where PC is the value already advanced past the offset byte. `done` follows in the next cycle, and no read is issued.
- R7: In the indirect modes, `mem_rd_en` is high in the first and second cycles after the start cycle, for the low and high byte addresses in that order. `mem_rd_data` is taken one cycle after each read. `done` rises in the fourth cycle after the start cycle, and every read address lies in page zero.
- R8: `busy` is high in the three cycles after an accepted indirect start. A `start` seen while `busy` is high is ignored. A `start` in the cycle `done` is high is accepted.
- R9: `eff_addr` keeps its value in every cycle in which `done` is low.
- R10: Mode codes 5, 6 and 7 behave exactly as mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| mode | input | 3 | Addressing mode code (see R2 to R6, R10) |
| operand | input | 8 | Operand byte following the opcode |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Program counter after the operand byte |
| mem_addr | output | 16 | Read address for pointer bytes |
| mem_rd_en | output | 1 | Read request |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | One-cycle result strobe |
| eff_addr | output | 16 | Effective address, valid with done |

## Verification
The bench builds the unit with the default 8-bit data width, which gives a 256-byte page zero and a 64K address space. That size lets every wrap corner be driven directly: index sums past 0xFF, a pointer whose low byte sits at 0xFF, a pointer plus Y crossing 0xFFFF, and branches across both ends of memory. Random traffic with gaps of zero to four cycles between starts also lands starts inside busy windows and in done cycles.

// File: rtl/eag_pkg.sv
package eag_pkg;

  // Mode codes seen on the mode port; codes 5..7 fall back to zero-page X.
  typedef enum logic [2:0] {
    MODE_ZPX = 3'd0,
    MODE_ZPY = 3'd1,
    MODE_IZX = 3'd2,
    MODE_IZY = 3'd3,
    MODE_REL = 3'd4
  } eag_mode_e;

  // Pointer fetch sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_FIN   = 2'd3
  } eag_state_e;

  function automatic logic mode_is_ptr(input logic [2:0] m);
    return (m == MODE_IZX) || (m == MODE_IZY);
  endfunction

endpackage

// File: rtl/eag_direct.sv
// Combinational part: single-cycle addresses and the page-zero pointer base.
module eag_direct
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] direct_ea_o,
  output logic [DATA_W-1:0] ptr_base_o,
  output logic              is_ptr_o,
  output logic              add_y_o
);

  // Sum confined to page zero: the carry out of the byte is discarded.
  function automatic logic [DATA_W-1:0] zp_wrap(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  // Signed byte displacement applied to the program counter, modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] p,
                                                   input logic [DATA_W-1:0] off);
    logic [ADDR_W-1:0] sx;
    sx = {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
    return p + sx;
  endfunction

  eag_mode_e mode_e;

  always_comb begin
    mode_e = eag_mode_e'(mode_i);
    unique case (mode_e)
      MODE_ZPY: direct_ea_o = {{(ADDR_W-DATA_W){1'b0}}, zp_wrap(operand_i, y_i)};
      MODE_REL: direct_ea_o = rel_target(pc_i, operand_i);
      default:  direct_ea_o = {{(ADDR_W-DATA_W){1'b0}}, zp_wrap(operand_i, x_i)};
    endcase
    ptr_base_o = (mode_e == MODE_IZX) ? zp_wrap(operand_i, x_i) : operand_i;
    is_ptr_o   = mode_is_ptr(mode_i);
    add_y_o    = (mode_e == MODE_IZY);
  end

endmodule

// File: rtl/eag_ptr_seq.sv
// Two-read pointer fetch from page zero with one-cycle read latency.
module eag_ptr_seq
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              add_y_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic [ADDR_W-1:0] ptr_ea_o
);

  eag_state_e        state_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] y_q;
  logic              add_y_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] byte_addr;
  logic [ADDR_W-1:0] pointer;

  function automatic logic [ADDR_W-1:0] post_index(input logic [ADDR_W-1:0] p,
                                                   input logic [DATA_W-1:0] y);
    return p + {{(ADDR_W-DATA_W){1'b0}}, y};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      y_q     <= '0;
      add_y_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_RD_LO;
          base_q  <= base_i;
          y_q     <= y_i;
          add_y_q <= add_y_i;
        end
        ST_RD_LO: state_q <= ST_RD_HI;
        ST_RD_HI: begin
          state_q <= ST_FIN;
          lo_q    <= rd_data_i;   // answer to the low-byte read
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    byte_addr = (state_q == ST_RD_HI) ? base_q + 1'b1 : base_q;  // wraps in page zero
    rd_en_o   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    rd_addr_o = {{(ADDR_W-DATA_W){1'b0}}, byte_addr};
    busy_o    = (state_q != ST_IDLE);
    fin_o     = (state_q == ST_FIN);
    pointer   = {rd_data_i, lo_q};                               // high byte arrives now
    ptr_ea_o  = add_y_q ? post_index(pointer, y_q) : pointer;
  end

endmodule

// File: rtl/eag_result.sv
// Output register: one-cycle strobe and held address.
module eag_result #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              direct_fire_i,
  input  logic [ADDR_W-1:0] direct_ea_i,
  input  logic              ptr_fire_i,
  input  logic [ADDR_W-1:0] ptr_ea_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] ea_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      ea_o   <= '0;
    end else begin
      done_o <= direct_fire_i | ptr_fire_i;
      if (ptr_fire_i)         ea_o <= ptr_ea_i;
      else if (direct_fire_i) ea_o <= direct_ea_i;
    end
  end

endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] eff_addr
);

  // Named internal events, visible to the bound checker.
  logic              accept;
  logic              launch;
  logic              direct_fire;
  logic              ptr_fire;
  logic              is_ptr;
  logic              add_y;
  logic [DATA_W-1:0] ptr_base;
  logic [ADDR_W-1:0] direct_ea;
  logic [ADDR_W-1:0] ptr_ea;

  assign accept      = start && !busy;
  assign launch      = accept && is_ptr;
  assign direct_fire = accept && !is_ptr;

  eag_direct #(.DATA_W(DATA_W)) u_direct (
    .mode_i      (mode),
    .operand_i   (operand),
    .x_i         (idx_x),
    .y_i         (idx_y),
    .pc_i        (pc),
    .direct_ea_o (direct_ea),
    .ptr_base_o  (ptr_base),
    .is_ptr_o    (is_ptr),
    .add_y_o     (add_y)
  );

  eag_ptr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .base_i    (ptr_base),
    .add_y_i   (add_y),
    .y_i       (idx_y),
    .rd_data_i (mem_rd_data),
    .rd_en_o   (mem_rd_en),
    .rd_addr_o (mem_addr),
    .busy_o    (busy),
    .fin_o     (ptr_fire),
    .ptr_ea_o  (ptr_ea)
  );

  eag_result #(.ADDR_W(ADDR_W)) u_result (
    .clk           (clk),
    .rst_n         (rst_n),
    .direct_fire_i (direct_fire),
    .direct_ea_i   (direct_ea),
    .ptr_fire_i    (ptr_fire),
    .ptr_ea_i      (ptr_ea),
    .done_o        (done),
    .ea_o          (eff_addr)
  );

endmodule

// File: rtl/eag_checks.sv
module eag_checks #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              launch,
  input logic              direct_fire
);

  // R7: reads only happen inside a busy window
  a_r7_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  // R4 / R5: every pointer read stays in page zero
  a_r4_r5_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[ADDR_W-1:DATA_W] == '0));

  // R5: second read is the next byte of page zero, wrapping at the top
  a_r5_hi_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_addr[DATA_W-1:0] == DATA_W'($past(mem_addr[DATA_W-1:0]) + 1'b1)));

  // R7 / R8: fixed indirect schedule
  a_r7_ptr_schedule: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (mem_rd_en && busy) ##1 (mem_rd_en && busy) ##1 (!mem_rd_en && busy)
               ##1 (done && !busy));

  // R2: direct modes finish in one cycle without reading
  a_r2_direct_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    direct_fire |=> (done && !busy && !mem_rd_en));

  // R8: a start during busy does not launch anything
  a_r8_busy_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !launch && !direct_fire);

  // R9: result only moves together with the strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_addr) |-> done);

endmodule

bind eag_top eag_checks #(.DATA_W(DATA_W)) u_eag_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .eff_addr    (eff_addr),
  .launch      (launch),
  .direct_fire (direct_fire)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  operand = 8'd0;
  logic [7:0]  idx_x = 8'd0;
  logic [7:0]  idx_y = 8'd0;
  logic [15:0] pc = 16'd0;
  logic [15:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_data = 8'd0;
  logic        busy;
  logic        done;
  logic [15:0] eff_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] zmem [256];

  always #2 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
    .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .busy(busy),
    .done(done), .eff_addr(eff_addr)
  );

  // Page-zero memory with one cycle of read latency.
  always @(posedge clk) mem_rd_data <= mem_rd_en ? zmem[mem_addr[7:0]] : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  int          m_cnt = 0;
  bit          m_done = 0;
  logic [15:0] m_ea = 0;
  logic [15:0] m_pend = 0;
  int          m_lo_a = 0;
  int          m_hi_a = 0;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_ea = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_done = 1; m_ea = m_pend; end
      end else if (start) begin
        int b; int lo; int hi; int off;
        case (mode)
          3'd1: begin m_ea = 16'((operand + idx_y) % 256); m_done = 1; m_tag = "R3"; end
          3'd2: begin
            b = (operand + idx_x) % 256;
            m_lo_a = b; m_hi_a = (b + 1) % 256;
            lo = zmem[m_lo_a]; hi = zmem[m_hi_a];
            m_pend = 16'(hi * 256 + lo); m_cnt = 3; m_tag = "R4";
          end
          3'd3: begin
            m_lo_a = operand; m_hi_a = (operand + 1) % 256;
            lo = zmem[m_lo_a]; hi = zmem[m_hi_a];
            m_pend = 16'((hi * 256 + lo + idx_y) % 65536); m_cnt = 3; m_tag = "R5";
          end
          3'd4: begin
            off = (operand >= 128) ? operand - 256 : operand;
            m_ea = 16'((pc + off + 65536) % 65536); m_done = 1; m_tag = "R6";
          end
          3'd0: begin m_ea = 16'((operand + idx_x) % 256); m_done = 1; m_tag = "R2"; end
          default: begin m_ea = 16'((operand + idx_x) % 256); m_done = 1; m_tag = "R10"; end
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == m_done, m_tag, done, m_done);
      chk(eff_addr == m_ea, m_done ? m_tag : "R9", eff_addr, m_ea);
      chk(busy == (m_cnt > 0), "R8", busy, m_cnt > 0);
      chk(mem_rd_en == (m_cnt == 3 || m_cnt == 2), "R7", mem_rd_en, m_cnt);
      if (m_cnt == 3) chk(mem_addr == 16'(m_lo_a), {m_tag, " lo read"}, mem_addr, m_lo_a);
      if (m_cnt == 2) chk(mem_addr == 16'(m_hi_a), {m_tag, " hi read"}, mem_addr, m_hi_a);
    end
  end

  task automatic issue(input logic [2:0] m, input logic [7:0] op, input logic [7:0] x,
                       input logic [7:0] y, input logic [15:0] p);
    mode = m; operand = op; idx_x = x; idx_y = y; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) zmem[i] = 8'($urandom);
    zmem[8'hFF] = 8'hF0; zmem[8'h00] = 8'hFF;   // pointer 0xFFF0 straddling page top
    zmem[8'h40] = 8'h34; zmem[8'h41] = 8'h12;   // pointer 0x1234
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", done, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(mem_rd_en == 1'b0, "R1", mem_rd_en, 0);
    chk(eff_addr == 16'h0000, "R1", eff_addr, 0);
    rst_n = 1'b1;
    idle(2);

    issue(3'd0, 8'hF0, 8'h20, 8'h00, 16'h0000); idle(2);   // R2 wrap to 0x0010
    issue(3'd1, 8'hFF, 8'h00, 8'h01, 16'h0000); idle(2);   // R3 wrap to 0x0000
    issue(3'd2, 8'hFE, 8'h01, 8'h00, 16'h0000); idle(5);   // R4 reads FF then 00
    issue(3'd2, 8'h3F, 8'h01, 8'h55, 16'h0000); idle(5);   // R4 pointer 0x1234
    issue(3'd3, 8'hFF, 8'h00, 8'h20, 16'h0000); idle(5);   // R5 0xFFF0+0x20 -> 0x0010
    issue(3'd3, 8'h40, 8'hAA, 8'h0C, 16'h0000); idle(5);   // R5 0x1240
    issue(3'd4, 8'hF0, 8'h00, 8'h00, 16'h0005); idle(2);   // R6 backward past 0 -> 0xFFF5
    issue(3'd4, 8'h7F, 8'h00, 8'h00, 16'hFFF0); idle(2);   // R6 forward past top -> 0x006F
    issue(3'd4, 8'h80, 8'h00, 8'h00, 16'h1000); idle(2);   // R6 most negative -> 0x0F80
    issue(3'd5, 8'h10, 8'h05, 8'h77, 16'h0000); idle(2);   // R10
    issue(3'd6, 8'hFF, 8'h02, 8'h77, 16'h0000); idle(2);   // R10
    issue(3'd7, 8'h01, 8'h01, 8'h77, 16'h0000); idle(2);   // R10
    // R8: starts during busy dropped, start in done cycle taken
    issue(3'd3, 8'h40, 8'h00, 8'h01, 16'h0000);
    issue(3'd0, 8'h11, 8'h11, 8'h00, 16'h0000);
    issue(3'd4, 8'h22, 8'h00, 8'h00, 16'h2000);
    issue(3'd1, 8'h33, 8'h00, 8'h00, 16'h0000);
    issue(3'd0, 8'h44, 8'h01, 8'h00, 16'h0000);            // lands in the done cycle
    idle(3);
    // R9 with other inputs moving and no start
    mode = 3'd4; operand = 8'h99; pc = 16'hABCD; idle(4);

    for (int n = 0; n < 400; n++) begin
      issue(3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
      idle($urandom % 5);
    end
    idle(6);
    finish_run();
  end

endmodule